// File: doc/BRIEF.md
# Dual-Ratio Fractional Clock Divider

This block turns a fast crystal clock into a slow core-clock enable of about 32.768 kHz. A single integer ratio cannot hit that rate exactly. The block therefore switches between two integer ratios. It runs a programmed number of periods at the first ratio, then a programmed number at the second, and loops. The average period lands between the two ratios.

Two 32-bit configuration words set the behaviour. They hold:
- both ratios and both repeat counts;
- a dual-mode switch and a bypass switch;
- separate input and output enables.

The result is a one-cycle pulse, `tick_o`, once per divided period. Downstream logic uses it as a clock enable. A status output shows whether the divider is switched on. A typical setting alternates 8 periods of 733 cycles with 11 periods of 732 cycles.

Software first clears both enables. It then writes the fields, selects dual mode and clears bypass. Last, it sets both enables again.

Top module: `frac_clk_div`

## Requirements
- R1: Configuration word 0 (`cfg0_i`) holds:
  - ratio A in bits [11:0];
  - ratio B in bits [23:12];
  - dual mode in bit 28;
  - output enable in bit 30;
  - input enable in bit 31.
- R1 (continued): Configuration word 1 (`cfg1_i`) holds:
  - repeat count A in bits [11:0];
  - repeat count B in bits [23:12];
  - bypass in bit 24.
- R1 (continued): Each ratio and count field stores its value minus one.
- R2: With dual mode clear and bypass clear, `tick_o` pulses high for one cycle every A input cycles. A ratio of at least 2 is assumed. After both enables rise together, the first pulse is high in the cycle that follows the (A-1)-th rising edge sampling them.
- R3: With dual mode set, the period sequence is fixed. It is count-A periods of A cycles, then count-B periods of B cycles, repeated, always starting with the A phase.
- R4: With bypass set and both enables set, division stops and `tick_o` is high in every cycle. This starts from the cycle after the first rising edge that samples those settings.
- R5: While the input enable is clear, `tick_o` stays low even if the output enable is set. Period, repeat and phase state are held at their start. Setting the input enable again restarts at the first period of the A phase.
- R6: The output enable is sampled in the first cycle of each period. A period whose start saw it set produces its pulse. A period whose start saw it clear produces none, regardless of later changes. This prevents runt pulses.
- R7: `enabled_o` is high whenever the input enable or the output enable is set, and follows the configuration without delay.
- R8: During and right after reset, `tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg0_i | input | 32 | Configuration word 0: ratios, dual mode, enables |
| cfg1_i | input | 32 | Configuration word 1: repeat counts, bypass |
| tick_o | output | 1 | One-cycle pulse per divided period |
| enabled_o | output | 1 | Divider switched on (either enable set) |

## Verification
Pulse timing depends on edge counts after the configuration changes.
- The first pulse after enabling is due N-1 rising edges later. Each later pulse follows N edges after the one before.
- A bypass output is high from the second sampled edge.
- A changed output enable acts only from the next period start, so it shows up in the current or the following whole period.
- `enabled_o` responds without delay.

The bench drives inputs one time unit after a rising edge and samples on the falling edge. It counts falling edges from each configuration change and compares pulse positions and gaps with a schedule computed from the ratio and count values. The output-enable tests are aligned to a known counter position. Each pulse window is then counted as a whole period.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int DIV_W    = 12;
  localparam int SLOTS    = 2;
  localparam int A_LSB    = 0;
  localparam int B_LSB    = A_LSB + DIV_W;
  localparam int DUAL_BIT = 28;
  localparam int OEN_BIT  = 30;
  localparam int IEN_BIT  = 31;
  localparam int BYP_BIT  = 24;

  typedef struct packed {
    logic dual;
    logic bypass;
    logic in_en;
    logic out_en;
  } div_ctl_t;

  function automatic div_ctl_t get_ctl(logic [31:0] w0, logic [31:0] w1);
    div_ctl_t c;
    c.dual   = w0[DUAL_BIT];
    c.bypass = w1[BYP_BIT];
    c.in_en  = w0[IEN_BIT];
    c.out_en = w0[OEN_BIT];
    return c;
  endfunction
endpackage

// File: rtl/frac_div_cfg_decode.sv
module frac_div_cfg_decode
  import frac_div_pkg::*;
(
  input  logic [31:0]                  cfg0_i,
  input  logic [31:0]                  cfg1_i,
  output logic [SLOTS-1:0][DIV_W-1:0]  div_lim_o,
  output logic [SLOTS-1:0][DIV_W-1:0]  rep_lim_o,
  output div_ctl_t                     ctl_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int LSB = A_LSB + s * DIV_W;
    assign div_lim_o[s] = cfg0_i[LSB +: DIV_W];
    assign rep_lim_o[s] = cfg1_i[LSB +: DIV_W];
  end

  assign ctl_o = get_ctl(cfg0_i, cfg1_i);
endmodule

// File: rtl/frac_div_period_ctr.sv
module frac_div_period_ctr #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         wrap_o,
  output logic         start_o
);
  logic [W-1:0] cnt_q;

  // >= so a shrinking limit mid-period cannot run away
  assign wrap_o  = run_i && (cnt_q >= lim_i);
  assign start_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || wrap_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assert_wrap_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> start_o);

  assert_idle_holds_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> start_o);
endmodule

// File: rtl/frac_div_phase_seq.sv
module frac_div_phase_seq #(
  parameter int W     = 12,
  parameter int SLOTS = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      run_i,
  input  logic                      wrap_i,
  input  logic                      dual_i,
  input  logic [SLOTS-1:0][W-1:0]   rep_lim_i,
  output logic                      phase_o
);
  logic [W-1:0] rep_q;
  logic         phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q   <= '0;
      phase_q <= 1'b0;
    end else if (!run_i) begin
      rep_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap_i) begin
      if (!dual_i) begin
        rep_q   <= '0;
        phase_q <= 1'b0;
      end else if (rep_q >= rep_lim_i[phase_q]) begin
        rep_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        rep_q   <= rep_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;

  assert_single_stays_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !dual_i) |=> !phase_o);

  assert_idle_phase_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !phase_o);

  assert_phase_moves_on_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i) |=> $stable(phase_o));
endmodule

// File: rtl/frac_div_out_gate.sv
module frac_div_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic out_en_i,
  output logic gate_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gate_q <= 1'b0;
    else if (load_i) gate_q <= out_en_i;
  end

  assign gate_o = gate_q;

  assert_gate_only_at_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(gate_o));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_div_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cfg0_i,
  input  logic [31:0] cfg1_i,
  output logic        tick_o,
  output logic        enabled_o
);
  logic [SLOTS-1:0][DIV_W-1:0] div_lim;
  logic [SLOTS-1:0][DIV_W-1:0] rep_lim;
  div_ctl_t                    ctl;
  logic                        run, wrap, start, phase, gate;
  logic [DIV_W-1:0]            lim;

  frac_div_cfg_decode u_dec (
    .cfg0_i    (cfg0_i),
    .cfg1_i    (cfg1_i),
    .div_lim_o (div_lim),
    .rep_lim_o (rep_lim),
    .ctl_o     (ctl)
  );

  assign run = ctl.in_en && !ctl.bypass;
  assign lim = (ctl.dual && phase) ? div_lim[1] : div_lim[0];

  frac_div_period_ctr #(.W(DIV_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .lim_i   (lim),
    .wrap_o  (wrap),
    .start_o (start)
  );

  frac_div_phase_seq #(.W(DIV_W), .SLOTS(SLOTS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .wrap_i    (wrap),
    .dual_i    (ctl.dual),
    .rep_lim_i (rep_lim),
    .phase_o   (phase)
  );

  // gate reloads only at period start (or while idle): no runt pulses
  frac_div_out_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (!ctl.in_en || start),
    .out_en_i (ctl.out_en),
    .gate_o   (gate)
  );

  assign tick_o    = ctl.in_en && gate && (ctl.bypass || wrap);
  assign enabled_o = ctl.in_en || ctl.out_en;

  assert_no_tick_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl.in_en) |-> !tick_o);
endmodule

// File: tb/frac_clk_div_tb_top.sv
`timescale 1ns/1ps
module frac_clk_div_tb_top;
  localparam real CLK_HALF = 2.5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg0 = '0;
  logic [31:0] cfg1 = '0;
  logic        tick, enabled;

  int checks = 0;
  int errors = 0;

  always #(CLK_HALF) clk = ~clk;

  frac_clk_div dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cfg0_i    (cfg0),
    .cfg1_i    (cfg1),
    .tick_o    (tick),
    .enabled_o (enabled)
  );

  // n1, n2, m1, m2 (true values, 8 bits each), dual
  localparam logic [32:0] VECS [5] = '{
    {8'd2, 8'd3, 8'd1, 8'd1, 1'b1},
    {8'd9, 8'd4, 8'd3, 8'd2, 1'b0},
    {8'd3, 8'd5, 8'd3, 8'd2, 1'b1},
    {8'd7, 8'd2, 8'd1, 8'd1, 1'b0},
    {8'd6, 8'd4, 8'd2, 8'd3, 1'b1}
  };

  function automatic logic [31:0] mk0(int n1, int n2, bit dual, bit oen, bit ien);
    logic [31:0] r = '0;
    r[11:0]  = 12'(n1 - 1);
    r[23:12] = 12'(n2 - 1);
    r[28]    = dual;
    r[30]    = oen;
    r[31]    = ien;
    return r;
  endfunction

  function automatic logic [31:0] mk1(int m1, int m2, bit byp);
    logic [31:0] r = '0;
    r[11:0]  = 12'(m1 - 1);
    r[23:12] = 12'(m2 - 1);
    r[24]    = byp;
    return r;
  endfunction

  function automatic int exp_gap(int p, int n1, int n2, int m1, int m2, bit dual);
    if (!dual) return n1;
    return ((p % (m1 + m2)) < m1) ? n1 : n2;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(logic [31:0] w0, logic [31:0] w1);
    @(posedge clk); #1;
    cfg0 = w0;
    cfg1 = w1;
  endtask

  // Enables must have just been set; measures pulse positions and gaps
  task automatic measure(int n1, int n2, int m1, int m2, bit dual, int periods, string req);
    int k = 0, last = 0, p = 0;
    int limit = (n1 > n2 ? n1 : n2) * (periods + 2) + 4;
    while (p < periods && k < limit) begin
      @(negedge clk);
      if (tick) begin
        if (p == 0) check(k == n1 - 1, req, k, n1 - 1);
        else check(k - last == exp_gap(p, n1, n2, m1, m2, dual), req, k - last,
                   exp_gap(p, n1, n2, m1, m2, dual));
        last = k;
        p++;
      end
      k++;
    end
    check(p == periods, req, p, periods);
  endtask

  task automatic run_cfg(int n1, int n2, int m1, int m2, bit dual, int periods, string req);
    drive(mk0(n1, n2, dual, 0, 0), mk1(m1, m2, 0));
    repeat (2) @(posedge clk);
    drive(mk0(n1, n2, dual, 1, 1), mk1(m1, m2, 0));
    measure(n1, n2, m1, m2, dual, periods, req);
    drive(mk0(n1, n2, dual, 0, 0), mk1(m1, m2, 0));
  endtask

  task automatic count_ticks(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    // R8 reset state
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R8 tick in reset", tick, 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R8 tick after reset", tick, 0);
    check(enabled == 1'b0, "R7 enabled idle", enabled, 0);

    // R7 status from either enable
    drive(mk0(4, 4, 0, 0, 1), mk1(1, 1, 0));
    @(negedge clk);
    check(enabled == 1'b1, "R7 input enable only", enabled, 1);
    drive(mk0(4, 4, 0, 1, 0), mk1(1, 1, 0));
    @(negedge clk);
    check(enabled == 1'b1, "R7 output enable only", enabled, 1);

    // R5 output enabled without input enable: no pulses
    count_ticks(30, c);
    check(c == 0, "R5 no tick without input enable", c, 0);
    drive(mk0(4, 4, 0, 0, 0), mk1(1, 1, 0));
    @(negedge clk);
    check(enabled == 1'b0, "R7 both clear", enabled, 0);

    // R1 R2 R3 vector table
    foreach (VECS[i]) begin
      int n1 = int'(VECS[i][32:25]);
      int n2 = int'(VECS[i][24:17]);
      int m1 = int'(VECS[i][16:9]);
      int m2 = int'(VECS[i][8:1]);
      bit du = VECS[i][0];
      run_cfg(n1, n2, m1, m2, du, 2 * (m1 + m2) + 1, du ? "R3 dual sequence" : "R2 single period");
    end

    // R1 R3 representative setting, one full cycle plus one period
    run_cfg(733, 732, 8, 11, 1, 20, "R1 R3 representative");

    // R4 bypass
    drive(mk0(5, 5, 0, 0, 0), mk1(1, 1, 1));
    repeat (2) @(posedge clk);
    drive(mk0(5, 5, 0, 1, 1), mk1(1, 1, 1));
    @(negedge clk);
    count_ticks(8, c);
    check(c == 8, "R4 bypass every cycle", c, 8);
    drive(mk0(5, 5, 0, 0, 0), mk1(1, 1, 0));

    // R5 restart at A phase after input enable drops mid B phase
    drive(mk0(4, 6, 1, 1, 1), mk1(1, 2, 0));
    c = 0;
    while (c < 2) begin
      @(negedge clk);
      if (tick) c++;
    end
    repeat (2) @(negedge clk);
    drive(mk0(4, 6, 1, 1, 0), mk1(1, 2, 0));
    count_ticks(20, c);
    check(c == 0, "R5 no tick while input disabled", c, 0);
    drive(mk0(4, 6, 1, 1, 1), mk1(1, 2, 0));
    measure(4, 6, 1, 2, 1, 4, "R5 restart in A phase");
    drive(mk0(4, 6, 0, 0, 0), mk1(1, 2, 0));

    // R6 output enable changes mid-period
    drive(mk0(10, 10, 0, 1, 1), mk1(1, 1, 0));
    do @(negedge clk); while (!tick);
    repeat (3) @(posedge clk);
    #1 cfg0 = mk0(10, 10, 0, 0, 1);
    count_ticks(8, c);
    check(c == 1, "R6 current period finishes after clear", c, 1);
    count_ticks(10, c);
    check(c == 0, "R6 next period gated after clear", c, 0);
    repeat (3) @(posedge clk);
    #1 cfg0 = mk0(10, 10, 0, 1, 1);
    count_ticks(8, c);
    check(c == 0, "R6 current period stays gated after set", c, 0);
    count_ticks(10, c);
    check(c == 1, "R6 next period ticks after set", c, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule